// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides whether a received Ethernet frame is kept or dropped, judging only its 48-bit destination address. The six address bytes arrive in wire order, one per clock when `byte_vld` is high. `frame_start` marks the first byte. While the bytes arrive, a reflected CRC-32 runs over them one byte per clock. When the sixth byte is taken, the CRC gives a bin index into a multicast hash table. At the same time the address is compared with a bank of perfect-match slots.

The configuration inputs are static and set by register logic outside the block. They select the filtering modes, the hash table size (64, 128 or 256 bins), the table contents and the slot addresses. One cycle after the sixth byte, the block issues a one-cycle `verdict_vld` pulse with `accept` and `by_hash`. `by_hash` shows whether the accept came from a hash table hit.

Top module: `rx_da_filter`

## Requirements
- R1: After reset, and until a sixth address byte is taken, `verdict_vld`, `accept` and `by_hash` are low.
- R2: `verdict_vld` is high for exactly one cycle, in the cycle after the clock edge that takes the sixth byte. Bytes that arrive after the sixth and before the next `frame_start` are ignored and produce no verdict.
- R3: A byte taken with `frame_start` high is always byte 0 of a new address, even when an earlier address is still incomplete. The partial address is dropped and produces no verdict.
- R4: The hash index is computed as follows.
  - A CRC-32 is taken over the six bytes in wire order, least significant bit of each byte first, with the reflected polynomial 0xEDB88320 and a preset of all ones.
  - The result is inverted and bit-reversed.
  - The top N bits form the index, where N is 6, 7 or 8 for `hash_size` 0, 1 or 2.
  - The index selects bit `index` of `hash_tbl`. This is 32-bit word index[N-1:5], bit index[4:0].
- R5: The group bit is bit 0 of the first byte. With hash mode on, a non-broadcast group address is accepted when its bin bit is set, with `by_hash`=1, and rejected when the bit is clear (unless R10 applies).
- R6: With pass-all-group on, every non-broadcast group address is accepted without a lookup, with `by_hash`=0.
- R7: With `promisc` on, every address is accepted, with `by_hash`=0.
- R8: With `rx_all` on, every address is accepted, with `by_hash`=0.
- R9: An address that equals a nonzero perfect-match slot hits that slot. A slot holding all zeros never hits. Slot k occupies bits [48k+47:48k] of `slot_addr`, with the first wire byte in the top 8 bits.
- R10: With hash mode and `hash_or_perf` on, a group address is accepted when the hash bin or any slot hits. `by_hash` is 1 only when the bin hits.
- R11: The broadcast address (all ones) is accepted with `by_hash`=0 unless `bcast_block` is set. When `bcast_block` is set it is rejected, except when R7 or R8 apply.
- R12: A unicast address, and a group address with neither hash mode nor pass-all-group on, is accepted only on a perfect-match hit, with `by_hash`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Marks the byte on `byte_in` as byte 0 of an address |
| byte_vld | input | 1 | `byte_in` holds an address byte |
| byte_in | input | 8 | Address byte, wire order |
| promisc | input | 1 | Accept all frames |
| rx_all | input | 1 | Accept all frames (debug) |
| pass_all_grp | input | 1 | Accept every group address |
| hash_grp | input | 1 | Filter group addresses through the hash table |
| hash_or_perf | input | 1 | Accept on a hash hit or a perfect-match hit |
| bcast_block | input | 1 | Reject the broadcast address |
| hash_size | input | 2 | 0: 64 bins, 1: 128 bins, 2: 256 bins |
| hash_tbl | input | 256 | Bin bits, bin i at bit i |
| slot_addr | input | 192 | Perfect-match slots, 48 bits each |
| verdict_vld | output | 1 | Verdict pulse |
| accept | output | 1 | Frame accepted |
| by_hash | output | 1 | Accept came from a hash bin hit |

## Verification
The only timed result is the verdict. It is due at the first negative edge after the clock edge that takes the sixth byte. The bench drives bytes at negative edges and samples `verdict_vld`, `accept` and `by_hash` exactly one cycle after the last byte. At the following negative edge it checks that `verdict_vld` has dropped again, which confirms the one-cycle pulse. For restarted and overlong byte streams, it also watches `verdict_vld` on every cycle in which a verdict must not appear. Expected values come from a CRC model inside the bench, for each of the three table sizes.

// File: rtl/rx_da_filter_pkg.sv
package rx_da_filter_pkg;

    localparam int          ADDR_BYTES = 6;
    localparam int          ADDR_W     = 8 * ADDR_BYTES;
    localparam logic [31:0] CRC_POLY   = 32'hEDB8_8320;
    localparam logic [31:0] CRC_PRESET = 32'hFFFF_FFFF;

    // One byte of the reflected CRC, least significant bit first
    function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        logic        fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ b[i];
            r  = r >> 1;
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    typedef struct packed {
        logic       active;
        logic [2:0] cnt;
        logic [ADDR_W-9:0] addr;
        logic       vld;
        logic       acc;
        logic       hh;
    } filt_state_t;

endpackage

// File: rtl/rx_da_crc.sv
module rx_da_crc
    import rx_da_filter_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        restart,
    input  logic        step,
    input  logic [7:0]  byte_in,
    output logic [31:0] crc_next
);
    logic [31:0] crc_d, crc_q;

    always_comb begin
        crc_next = crc_step(restart ? CRC_PRESET : crc_q, byte_in);
        crc_d    = step ? crc_next : crc_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= CRC_PRESET;
        else        crc_q <= crc_d;
    end

    // R4: a restarted step always begins from the preset value
    crc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && restart) |=> (crc_q == crc_step(CRC_PRESET, $past(byte_in))));
endmodule

// File: rtl/rx_da_hash.sv
module rx_da_hash #(
    parameter int MAX_LOG2 = 8
) (
    input  logic [31:0]            crc,
    input  logic [1:0]             size_sel,
    input  logic [2**MAX_LOG2-1:0] tbl,
    output logic                   hit
);
    localparam int BINS = 2**MAX_LOG2;

    logic [31:0]         rev;
    logic [31:0]         idx_full;
    logic [MAX_LOG2-1:0] idx;
    int                  nbits;

    always_comb begin
        for (int k = 0; k < 32; k++) rev[31-k] = ~crc[k];
        nbits = 6 + int'(size_sel);
        if (nbits > MAX_LOG2) nbits = MAX_LOG2;
        idx_full = rev >> (32 - nbits);
        idx      = idx_full[MAX_LOG2-1:0];
        hit      = tbl[idx];
    end
endmodule

// File: rtl/rx_da_perfect.sv
module rx_da_perfect #(
    parameter int N_SLOTS = 4,
    parameter int ADDR_W  = 48
) (
    input  logic [ADDR_W-1:0]         addr,
    input  logic [N_SLOTS*ADDR_W-1:0] slots,
    output logic                      hit
);
    logic [N_SLOTS-1:0] match;

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        logic [ADDR_W-1:0] entry;
        assign entry    = slots[s*ADDR_W +: ADDR_W];
        assign match[s] = (entry != '0) && (entry == addr);
    end

    assign hit = |match;
endmodule

// File: rtl/rx_da_filter.sv
module rx_da_filter
    import rx_da_filter_pkg::*;
#(
    parameter int N_SLOTS   = 4,
    parameter int HASH_LOG2 = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      frame_start,
    input  logic                      byte_vld,
    input  logic [7:0]                byte_in,
    input  logic                      promisc,
    input  logic                      rx_all,
    input  logic                      pass_all_grp,
    input  logic                      hash_grp,
    input  logic                      hash_or_perf,
    input  logic                      bcast_block,
    input  logic [1:0]                hash_size,
    input  logic [2**HASH_LOG2-1:0]   hash_tbl,
    input  logic [N_SLOTS*ADDR_W-1:0] slot_addr,
    output logic                      verdict_vld,
    output logic                      accept,
    output logic                      by_hash
);
    localparam logic [2:0] LAST_IDX = 3'(ADDR_BYTES - 1);

    filt_state_t st_d, st_q;

    logic              take, last;
    logic [2:0]        idx;
    logic [ADDR_W-1:0] full_addr;
    logic [31:0]       crc_next;
    logic              hash_hit, perf_hit;
    logic              is_grp, is_bcast;

    assign take      = byte_vld && (frame_start || st_q.active);
    assign idx       = frame_start ? 3'd0 : st_q.cnt;
    assign last      = take && (idx == LAST_IDX);
    assign full_addr = {st_q.addr, byte_in};

    rx_da_crc u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (frame_start),
        .step     (take),
        .byte_in  (byte_in),
        .crc_next (crc_next)
    );

    rx_da_hash #(.MAX_LOG2(HASH_LOG2)) u_hash (
        .crc      (crc_next),
        .size_sel (hash_size),
        .tbl      (hash_tbl),
        .hit      (hash_hit)
    );

    rx_da_perfect #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W)) u_perf (
        .addr  (full_addr),
        .slots (slot_addr),
        .hit   (perf_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        st_d.acc = 1'b0;
        st_d.hh  = 1'b0;
        is_grp   = full_addr[ADDR_W-8];
        is_bcast = &full_addr;

        if (take) begin
            st_d.addr   = full_addr[ADDR_W-9:0];
            st_d.active = !last;
            st_d.cnt    = last ? 3'd0 : idx + 3'd1;
        end

        if (last) begin
            st_d.vld = 1'b1;
            if (rx_all || promisc) begin
                st_d.acc = 1'b1;
            end else if (is_bcast) begin
                st_d.acc = !bcast_block;
            end else if (is_grp && pass_all_grp) begin
                st_d.acc = 1'b1;
            end else if (is_grp && hash_grp) begin
                st_d.hh  = hash_hit;
                st_d.acc = hash_hit || (hash_or_perf && perf_hit);
            end else begin
                st_d.acc = perf_hit;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign verdict_vld = st_q.vld;
    assign accept      = st_q.acc;
    assign by_hash     = st_q.hh;

    // R2
    vld_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_vld |=> !verdict_vld);
    // R2
    vld_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_vld |-> $past(byte_vld));
    // R5
    hash_implies_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        by_hash |-> (accept && verdict_vld));
    // R1
    quiet_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !verdict_vld |-> (!accept && !by_hash));
    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= LAST_IDX);
endmodule

// File: tb/sim_rx_da_filter.sv
module sim_rx_da_filter;
    localparam int NS = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_start = 1'b0, byte_vld = 1'b0;
    logic [7:0] byte_in = '0;
    logic promisc = 0, rx_all = 0, pass_all_grp = 0, hash_grp = 0, hash_or_perf = 0, bcast_block = 0;
    logic [1:0] hash_size = 2'd0;
    logic [255:0] hash_tbl = '0;
    logic [NS*48-1:0] slot_addr;
    logic verdict_vld, accept, by_hash;

    int checks = 0, errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    localparam logic [47:0] SLOT0 = 48'h02_11_22_33_44_55;
    localparam logic [47:0] SLOT1 = 48'h0A_BB_CC_DD_EE_01;
    localparam logic [47:0] SLOT2 = 48'h01_00_5E_00_00_01;
    assign slot_addr = {48'h0, SLOT2, SLOT1, SLOT0};

    rx_da_filter #(.N_SLOTS(NS), .HASH_LOG2(8)) u0 (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_vld(byte_vld),
        .byte_in(byte_in), .promisc(promisc), .rx_all(rx_all), .pass_all_grp(pass_all_grp),
        .hash_grp(hash_grp), .hash_or_perf(hash_or_perf), .bcast_block(bcast_block),
        .hash_size(hash_size), .hash_tbl(hash_tbl), .slot_addr(slot_addr),
        .verdict_vld(verdict_vld), .accept(accept), .by_hash(by_hash));

    // vector: addr[47:0], mode {rx_all,promisc,pass,hash,hop,bblock}, size[1:0]
    localparam int NV = 14;
    localparam logic [55:0] VEC [NV] = '{
        {48'h02_11_22_33_44_55, 6'b000000, 2'd0},
        {48'h02_11_22_33_44_56, 6'b000000, 2'd0},
        {48'h0A_BB_CC_DD_EE_01, 6'b000100, 2'd1},
        {48'hFF_FF_FF_FF_FF_FF, 6'b000000, 2'd0},
        {48'hFF_FF_FF_FF_FF_FF, 6'b000001, 2'd0},
        {48'hFF_FF_FF_FF_FF_FF, 6'b010001, 2'd0},
        {48'h33_33_00_00_00_01, 6'b001000, 2'd2},
        {48'h33_33_00_00_00_01, 6'b000000, 2'd2},
        {48'h01_00_5E_7F_00_02, 6'b000100, 2'd0},
        {48'h01_00_5E_7F_00_02, 6'b000100, 2'd1},
        {48'h01_00_5E_7F_00_02, 6'b000100, 2'd2},
        {48'h00_00_00_00_00_00, 6'b000000, 2'd0},
        {48'h12_34_56_78_9A_BC, 6'b100000, 2'd1},
        {48'h01_00_5E_00_00_01, 6'b000110, 2'd2}
    };

    function automatic logic [7:0] ref_index(input logic [47:0] a, input logic [1:0] sz);
        logic [31:0] c = 32'hFFFF_FFFF;
        logic [7:0]  r = '0;
        int n = 6 + int'(sz);
        for (int by = 0; by < 6; by++)
            for (int bi = 0; bi < 8; bi++) begin
                logic d;
                d = a[47 - 8*by - 7 + bi];
                if (c[0] ^ d) c = (c >> 1) ^ 32'hEDB8_8320;
                else          c = c >> 1;
            end
        c = ~c;
        for (int k = 0; k < n; k++) r[n-1-k] = c[k];
        return r;
    endfunction

    function automatic logic [1:0] ref_verdict(input logic [47:0] a, input logic [1:0] sz);
        logic grp, bc, ph, hh;
        grp = a[40];
        bc  = (a == 48'hFFFF_FFFF_FFFF);
        ph  = (a == SLOT0) || (a == SLOT1) || (a == SLOT2);
        hh  = hash_tbl[ref_index(a, sz)];
        if (rx_all || promisc) return 2'b10;
        if (bc) return {!bcast_block, 1'b0};
        if (grp && pass_all_grp) return 2'b10;
        if (grp && hash_grp) return {hh || (hash_or_perf && ph), hh};
        return {ph, 1'b0};
    endfunction

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic put_byte(input logic s, input logic [7:0] b);
        @(negedge clk);
        frame_start = s; byte_vld = 1'b1; byte_in = b;
    endtask

    task automatic idle_and_check_none(input string req);
        @(negedge clk);
        frame_start = 0; byte_vld = 0;
        chk(req, {1'b0, verdict_vld}, 2'b00);
    endtask

    task automatic run(input logic [47:0] a, input string req);
        logic [1:0] e;
        e = ref_verdict(a, hash_size);
        for (int i = 0; i < 6; i++) put_byte(i == 0, a[47-8*i -: 8]);
        @(negedge clk);
        frame_start = 0; byte_vld = 0;
        chk({req, " vld"}, {1'b0, verdict_vld}, 2'b01);
        chk(req, {accept, by_hash}, e);
        @(negedge clk);
        chk({req, " pulse end"}, {1'b0, verdict_vld}, 2'b00);
    endtask

    task automatic set_mode(input logic [5:0] m);
        {rx_all, promisc, pass_all_grp, hash_grp, hash_or_perf, bcast_block} = m;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] ix;
        hash_tbl = {8{32'hA5C3_0F69}};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 reset", {verdict_vld, accept}, 2'b00);
        chk("R1 reset hash", {1'b0, by_hash}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle", {verdict_vld, by_hash}, 2'b00);

        // Vector walk: R4 R5 R6 R7 R8 R9 R10 R11 R12
        for (int v = 0; v < NV; v++) begin
            set_mode(VEC[v][7:2]);
            hash_size = VEC[v][1:0];
            run(VEC[v][55:8], $sformatf("R4-vec%0d R5 R6 R7 R8 R9 R10 R11 R12", v));
        end

        // R5 / R4: bin set then cleared, all three sizes
        set_mode(6'b000100);
        for (int sz = 0; sz < 3; sz++) begin
            hash_size = 2'(sz);
            ix = ref_index(48'h01_00_5E_12_34_56, 2'(sz));
            hash_tbl = '0;
            hash_tbl[ix] = 1'b1;
            run(48'h01_00_5E_12_34_56, "R4 R5 bin set");
            hash_tbl[ix] = 1'b0;
            run(48'h01_00_5E_12_34_56, "R5 bin clear");
        end

        // R10: hash-or-perfect, empty table, slot hit
        set_mode(6'b000110);
        hash_tbl = '0;
        run(SLOT2, "R10 perfect only");
        set_mode(6'b000100);
        run(SLOT2, "R10 off rejects");

        // R9: zero address against empty slot
        set_mode(6'b000000);
        run(48'h0, "R9 zero slot");

        // R3: restart mid-address
        set_mode(6'b000000);
        put_byte(1, 8'hDE); put_byte(0, 8'hAD); put_byte(0, 8'hBE);
        run(SLOT1, "R3 restart");

        // R2: extra bytes ignored
        run(SLOT0, "R2 base");
        for (int i = 0; i < 8; i++) begin
            put_byte(0, 8'h55);
            @(posedge clk); #1;
            chk("R2 extra ignored", {1'b0, verdict_vld}, 2'b00);
        end
        idle_and_check_none("R2 no late verdict");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule